// File: doc/BRIEF.md
# Nibble Accumulator ALU with Post-Shifter and Status Flags

This block is the arithmetic datapath of a small accumulator machine. One operand is always the accumulator. The second operand comes from a four-way selector: the B register, a constant one, a data-memory nibble or an immediate nibble. The adder and the logic unit produce a result, and a one-bit shifter placed after them can pass it, move it one place either way, or force it to zero. The shifter's output is the result nibble.

A four-bit status register holds carry, sign, zero and overflow. It is updated on the clock edge at the end of each operation. Which flags change depends on the class of the operation. Subtraction and negation reuse the single adder by inverting one of its inputs and choosing the carry-in, so every operation takes one cycle. A separate result-write strobe tells the surrounding machine whether to store the result, which lets compare touch only the flags.

The data width is a parameter, with a default of four. The adder can be built as an explicit ripple chain or left to the synthesis operator.

Top module: `nib_alu_core`

## Requirements
- R1: `src_sel_i` selects the second operand: 0 = `breg_i`, 1 = constant one, 2 = `dmem_i`, 3 = `imm_i`. With `op_i`=10 (load operand) and shift code 0, `result_o` equals the selected operand.
- R2: `op_i`=0 gives acc+opnd and `op_i`=1 gives acc+opnd+CF, both modulo 2^DW. CF is the carry out of the top bit.
- R3: `op_i`=2 gives acc-opnd and `op_i`=3 gives acc-opnd-CF. CF is set when the unsigned acc is less than opnd plus the incoming borrow. `op_i`=4 (compare) updates the flags as subtract does and holds `res_we_o` low. Every other code holds `res_we_o` high.
- R4: `op_i`=5 gives (~acc)+opnd with carry-in zero, so with `src_sel_i`=1 the result is the two's complement of acc in one cycle. CF is the adder's carry out.
- R5: For codes 0 to 5, VF is set when the two adder inputs (after any inversion) share a sign and the sum's sign differs. This is the same as the signed result falling outside the representable range.
- R6: Codes 6, 7, 8 and 9 give OR, XOR and AND with the operand, and the complement of acc. They update SF and ZF and leave CF and VF unchanged.
- R7: `shf_i` 0 passes the result, 1 shifts it right with a zero in the top bit, 2 shifts it left with a zero in the bottom bit, and 3 outputs zero. A one-place shift loads CF with the bit shifted out.
- R8: `op_i`=11 passes acc, and every code from 12 to 15 behaves the same way. These move codes and code 10 change no flag unless the shifter moves a bit, in which case they update CF, SF and ZF.
- R9: The flag bit order is CF bit 0, SF bit 1, ZF bit 2, VF bit 3. When updated, SF is the top bit of `result_o` and ZF is set when `result_o` is zero.
- R10: An active-low `rst_n` clears all flags at once. Otherwise the flags change only on the rising clock edge that ends an operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the flags |
| op_i | input | 4 | Operation code |
| src_sel_i | input | 2 | Second-operand select |
| shf_i | input | 2 | Post-shifter code |
| acc_i | input | DW | Accumulator value |
| breg_i | input | DW | B register value |
| dmem_i | input | DW | Data-memory nibble |
| imm_i | input | DW | Immediate nibble |
| result_o | output | DW | Result after the shifter |
| res_we_o | output | 1 | Result should be written (low for compare) |
| flags_o | output | 4 | Status flags {VF, ZF, SF, CF} |

## Verification
The assertions check the following on every cycle:
- compare never raises the write strobe;
- the zero shift code always yields zero;
- logic operations keep CF and VF;
- move codes without a shift freeze every flag;
- a left shift of acc loads the old top bit into CF;
- ZF follows the result that was written.

Only the bench's sweeps can show that the arithmetic values, the borrow and overflow conditions, the ADC/SBB carry chaining and the operand-select mapping are right. The bench compares each of them against arithmetic computed with signed and unsigned integers, over every operand pair and both incoming carry values.

// File: rtl/nib_alu_pkg.sv
package nib_alu_pkg;
   localparam logic [3:0] OP_ADD   = 4'd0;
   localparam logic [3:0] OP_ADC   = 4'd1;
   localparam logic [3:0] OP_SUB   = 4'd2;
   localparam logic [3:0] OP_SBB   = 4'd3;
   localparam logic [3:0] OP_CMP   = 4'd4;
   localparam logic [3:0] OP_NEG   = 4'd5;
   localparam logic [3:0] OP_OR    = 4'd6;
   localparam logic [3:0] OP_XOR   = 4'd7;
   localparam logic [3:0] OP_AND   = 4'd8;
   localparam logic [3:0] OP_NOT   = 4'd9;
   localparam logic [3:0] OP_LOAD  = 4'd10;
   localparam logic [3:0] OP_PASSA = 4'd11;

   localparam int FL_C = 0;
   localparam int FL_S = 1;
   localparam int FL_Z = 2;
   localparam int FL_V = 3;

   localparam logic [1:0] SH_PASS  = 2'd0;
   localparam logic [1:0] SH_RIGHT = 2'd1;
   localparam logic [1:0] SH_LEFT  = 2'd2;
   localparam logic [1:0] SH_ZERO  = 2'd3;

   typedef enum logic [1:0] {CLS_ARITH, CLS_LOGIC, CLS_MOVE} op_class_e;

   function automatic op_class_e class_of(logic [3:0] op);
      if (op <= OP_NEG)      return CLS_ARITH;
      else if (op <= OP_NOT) return CLS_LOGIC;
      else                   return CLS_MOVE;
   endfunction
endpackage

// File: rtl/nib_alu_opsel.sv
module nib_alu_opsel #(
   parameter int DW = 4
) (
   input  logic [1:0]    sel_i,
   input  logic [DW-1:0] breg_i,
   input  logic [DW-1:0] dmem_i,
   input  logic [DW-1:0] imm_i,
   output logic [DW-1:0] opnd_o
);
   localparam logic [DW-1:0] ONE = DW'(1);

   always_comb begin
      unique case (sel_i)
         2'd0:    opnd_o = breg_i;
         2'd1:    opnd_o = ONE;
         2'd2:    opnd_o = dmem_i;
         default: opnd_o = imm_i;
      endcase
   end
endmodule

// File: rtl/nib_alu_adder.sv
module nib_alu_adder #(
   parameter int DW     = 4,
   parameter bit RIPPLE = 1'b1
) (
   input  logic [DW-1:0] a_i,
   input  logic [DW-1:0] b_i,
   input  logic          cin_i,
   output logic [DW-1:0] sum_o,
   output logic          cout_o,
   output logic          ovf_o
);
   localparam int MSB = DW - 1;

   generate
      if (RIPPLE) begin : g_ripple
         logic [DW:0] cy;
         assign cy[0] = cin_i;
         for (genvar i = 0; i < DW; i++) begin : g_bit
            assign sum_o[i] = a_i[i] ^ b_i[i] ^ cy[i];
            assign cy[i+1]  = (a_i[i] & b_i[i]) | (cy[i] & (a_i[i] ^ b_i[i]));
         end
         assign cout_o = cy[DW];
      end else begin : g_behav
         logic [DW:0] wide;
         assign wide   = {1'b0, a_i} + {1'b0, b_i} + {{DW{1'b0}}, cin_i};
         assign sum_o  = wide[MSB:0];
         assign cout_o = wide[DW];
      end
   endgenerate

   assign ovf_o = (a_i[MSB] == b_i[MSB]) && (sum_o[MSB] != a_i[MSB]);
endmodule

// File: rtl/nib_alu_shift.sv
module nib_alu_shift #(
   parameter int DW = 4
) (
   input  logic [DW-1:0] d_i,
   input  logic [1:0]    code_i,
   output logic [DW-1:0] q_o,
   output logic          moved_o,
   output logic          out_bit_o
);
   import nib_alu_pkg::*;
   localparam int MSB = DW - 1;

   always_comb begin
      q_o       = d_i;
      moved_o   = 1'b0;
      out_bit_o = 1'b0;
      unique case (code_i)
         SH_RIGHT: begin
            q_o       = {1'b0, d_i[MSB:1]};
            moved_o   = 1'b1;
            out_bit_o = d_i[0];
         end
         SH_LEFT: begin
            q_o       = {d_i[MSB-1:0], 1'b0};
            moved_o   = 1'b1;
            out_bit_o = d_i[MSB];
         end
         SH_ZERO: q_o = '0;
         default: q_o = d_i;
      endcase
   end
endmodule

// File: rtl/nib_alu_flags.sv
module nib_alu_flags #(
   parameter int DW = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  nib_alu_pkg::op_class_e cls_i,
   input  logic                   moved_i,
   input  logic                   out_bit_i,
   input  logic                   add_c_i,
   input  logic                   add_v_i,
   input  logic [DW-1:0]          res_i,
   output logic [3:0]             flags_o
);
   import nib_alu_pkg::*;
   logic [3:0] nxt;

   always_comb begin
      nxt = flags_o;
      if (cls_i != CLS_MOVE || moved_i) begin
         nxt[FL_S] = res_i[DW-1];
         nxt[FL_Z] = (res_i == '0);
      end
      if (moved_i)                nxt[FL_C] = out_bit_i;
      else if (cls_i == CLS_ARITH) nxt[FL_C] = add_c_i;
      if (cls_i == CLS_ARITH)     nxt[FL_V] = add_v_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_o <= '0;
      else        flags_o <= nxt;
   end
endmodule

// File: rtl/nib_alu_core.sv
module nib_alu_core #(
   parameter int DW     = 4,
   parameter bit RIPPLE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [3:0]    op_i,
   input  logic [1:0]    src_sel_i,
   input  logic [1:0]    shf_i,
   input  logic [DW-1:0] acc_i,
   input  logic [DW-1:0] breg_i,
   input  logic [DW-1:0] dmem_i,
   input  logic [DW-1:0] imm_i,
   output logic [DW-1:0] result_o,
   output logic          res_we_o,
   output logic [3:0]    flags_o
);
   import nib_alu_pkg::*;

   generate
      if (DW < 2) begin : g_bad_width
         $error("nib_alu_core: DW must be at least 2");
      end
   endgenerate

   op_class_e     cls;
   logic [DW-1:0] opnd, add_a, add_b, add_sum, logic_res, alu_res;
   logic          add_cin, add_cout, add_ovf, borrow_mode, moved, out_bit;

   nib_alu_opsel #(.DW(DW)) u_opsel (
      .sel_i(src_sel_i), .breg_i(breg_i), .dmem_i(dmem_i),
      .imm_i(imm_i), .opnd_o(opnd)
   );

   always_comb begin
      add_a       = acc_i;
      add_b       = opnd;
      add_cin     = 1'b0;
      borrow_mode = 1'b0;
      unique case (op_i)
         OP_ADC: add_cin = flags_o[FL_C];
         OP_SUB, OP_CMP: begin
            add_b       = ~opnd;
            add_cin     = 1'b1;
            borrow_mode = 1'b1;
         end
         OP_SBB: begin
            add_b       = ~opnd;
            add_cin     = ~flags_o[FL_C];
            borrow_mode = 1'b1;
         end
         OP_NEG:  add_a = ~acc_i;
         default: add_a = acc_i;
      endcase
   end

   nib_alu_adder #(.DW(DW), .RIPPLE(RIPPLE)) u_adder (
      .a_i(add_a), .b_i(add_b), .cin_i(add_cin),
      .sum_o(add_sum), .cout_o(add_cout), .ovf_o(add_ovf)
   );

   always_comb begin
      unique case (op_i)
         OP_OR:   logic_res = acc_i | opnd;
         OP_XOR:  logic_res = acc_i ^ opnd;
         OP_AND:  logic_res = acc_i & opnd;
         OP_NOT:  logic_res = ~acc_i;
         OP_LOAD: logic_res = opnd;
         default: logic_res = acc_i;
      endcase
   end

   assign cls     = class_of(op_i);
   assign alu_res = (cls == CLS_ARITH) ? add_sum : logic_res;

   nib_alu_shift #(.DW(DW)) u_shift (
      .d_i(alu_res), .code_i(shf_i), .q_o(result_o),
      .moved_o(moved), .out_bit_o(out_bit)
   );

   nib_alu_flags #(.DW(DW)) u_flags (
      .clk(clk), .rst_n(rst_n), .cls_i(cls), .moved_i(moved),
      .out_bit_i(out_bit), .add_c_i(add_cout ^ borrow_mode),
      .add_v_i(add_ovf), .res_i(result_o), .flags_o(flags_o)
   );

   assign res_we_o = (op_i != OP_CMP);
endmodule

// File: rtl/nib_alu_chk.sv
module nib_alu_chk #(
   parameter int DW = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic [3:0]    op_i,
   input logic [1:0]    shf_i,
   input logic [DW-1:0] acc_i,
   input logic [DW-1:0] result_o,
   input logic          res_we_o,
   input logic [3:0]    flags_o
);
   assert_cmp_nowrite_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 4'd4) |-> !res_we_o);

   assert_zero_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (shf_i == 2'd3) |-> (result_o == '0));

   assert_shl_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 4'd11 && shf_i == 2'd2) |=> (flags_o[0] == $past(acc_i[DW-1])));

   assert_logic_keeps_cv_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i >= 4'd6 && op_i <= 4'd9 && shf_i == 2'd0)
      |=> (flags_o[0] == $past(flags_o[0]) && flags_o[3] == $past(flags_o[3])));

   assert_move_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i >= 4'd10 && shf_i == 2'd0) |=> $stable(flags_o));

   assert_zero_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i <= 4'd9 && shf_i == 2'd0) |=> (flags_o[2] == ($past(result_o) == '0)));

   always @(posedge clk) begin
      if (!rst_n) assert_reset_clear_R10: assert (flags_o == 4'd0);
   end
endmodule

bind nib_alu_core nib_alu_chk #(.DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .op_i(op_i), .shf_i(shf_i), .acc_i(acc_i),
   .result_o(result_o), .res_we_o(res_we_o), .flags_o(flags_o)
);

// File: tb/tb_nib_alu_core.sv
`timescale 1ns/1ps
module tb_nib_alu_core;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] op = 4'd11;
   logic [1:0] sel = 2'd0, shf = 2'd0;
   logic [3:0] acc = '0, breg = '0, dmem = '0, imm = '0;
   logic [3:0] result, flags;
   logic       res_we;
   int errors = 0, checks = 0;
   logic [3:0] mflags = 4'd0;

   always #2 clk = ~clk;

   nib_alu_core dut (
      .clk(clk), .rst_n(rst_n), .op_i(op), .src_sel_i(sel), .shf_i(shf),
      .acc_i(acc), .breg_i(breg), .dmem_i(dmem), .imm_i(imm),
      .result_o(result), .res_we_o(res_we), .flags_o(flags)
   );

   function automatic int sgn(int v);
      return (v >= 8) ? v - 16 : v;
   endfunction

   function automatic string req_of(logic [3:0] o, logic [1:0] s, logic [1:0] sh);
      if (sh != 2'd0)                 return "R7";
      if (o <= 4'd1)                  return "R2";
      if (o <= 4'd4)                  return "R3";
      if (o == 4'd5)                  return "R4";
      if (o <= 4'd9)                  return "R6";
      if (o == 4'd10 && s != 2'd0)    return "R1";
      return "R8";
   endfunction

   task automatic check(string req, int act, int exp, string what);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic apply(logic [3:0] o, logic [1:0] s, logic [3:0] av, logic [3:0] bv,
                        logic [3:0] mv, logic [3:0] iv, logic [1:0] sh);
      int a, b, cf, r, c, sv, fin, sout, ef;
      bit arith, logc, moved;
      string req;
      a = av; cf = mflags[0]; c = cf; sv = 0;
      case (s)
         2'd0: b = bv;
         2'd1: b = 1;
         2'd2: b = mv;
         default: b = iv;
      endcase
      arith = (o <= 4'd5); logc = (o >= 4'd6 && o <= 4'd9);
      case (o)
         4'd0: begin r = a + b;      c = r / 16; sv = sgn(a) + sgn(b); end
         4'd1: begin r = a + b + cf; c = r / 16; sv = sgn(a) + sgn(b) + cf; end
         4'd2, 4'd4: begin r = a - b; c = (a < b) ? 1 : 0; sv = sgn(a) - sgn(b); end
         4'd3: begin r = a - b - cf; c = (a < b + cf) ? 1 : 0; sv = sgn(a) - sgn(b) - cf; end
         4'd5: begin r = (15 - a) + b; c = r / 16; sv = sgn(15 - a) + sgn(b); end
         4'd6: r = a | b;
         4'd7: r = a ^ b;
         4'd8: r = a & b;
         4'd9: r = 15 - a;
         4'd10: r = b;
         default: r = a;
      endcase
      r = r & 15;
      if (r < 0) r = r + 16;
      moved = (sh == 2'd1 || sh == 2'd2);
      case (sh)
         2'd1: begin sout = r % 2; fin = r / 2; end
         2'd2: begin sout = r / 8; fin = (r * 2) % 16; end
         2'd3: begin sout = 0; fin = 0; end
         default: begin sout = 0; fin = r; end
      endcase
      ef = mflags;
      if (arith || logc || moved) begin
         ef[1] = (fin >= 8);
         ef[2] = (fin == 0);
      end
      if (moved) ef[0] = sout[0];
      else if (arith) ef[0] = c[0];
      if (arith) ef[3] = (sv > 7 || sv < -8);
      req = req_of(o, s, sh);
      @(negedge clk);
      op = o; sel = s; acc = av; breg = bv; dmem = mv; imm = iv; shf = sh;
      #0.5;
      check(req, result, fin, "result");
      check((o == 4'd4) ? "R3" : "R3_we", res_we, (o == 4'd4) ? 0 : 1, "write strobe");
      @(posedge clk);
      #0.5;
      check(arith ? "R5_R9" : req, flags, ef, "flags");
      mflags = ef[3:0];
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #0.5;
      check("R10", flags, 0, "flags in reset");
      @(negedge clk);
      rst_n = 1'b1;
      mflags = 4'd0;
      // main sweep: every code, every acc/B pair, incoming CF 0 and 1 (R2 R3 R4 R5 R6 R8 R9)
      for (int cin = 0; cin < 2; cin++)
         for (int oi = 0; oi < 13; oi++)
            for (int a = 0; a < 16; a++)
               for (int b = 0; b < 16; b++) begin
                  apply(4'd11, 2'd0, 4'(cin * 8), 4'd0, 4'd0, 4'd0, 2'd2);
                  apply((oi == 12) ? 4'd15 : 4'(oi), 2'd0, 4'(a), 4'(b), 4'd0, 4'd0, 2'd0);
               end
      // R4: negate with constant-one operand
      for (int a = 0; a < 16; a++) apply(4'd5, 2'd1, 4'(a), 4'd9, 4'd6, 4'd3, 2'd0);
      // R1: each operand source with distinct values
      for (int s = 0; s < 4; s++) begin
         apply(4'd10, 2'(s), 4'd2, 4'd5, 4'd12, 4'd9, 2'd0);
         apply(4'd0, 2'(s), 4'd7, 4'd3, 4'd10, 4'd14, 2'd0);
      end
      // R7: shifter codes over all acc values and three op classes
      for (int sh = 0; sh < 4; sh++)
         for (int a = 0; a < 16; a++) begin
            apply(4'd11, 2'd0, 4'(a), 4'd3, 4'd0, 4'd0, 2'(sh));
            apply(4'd0,  2'd0, 4'(a), 4'd3, 4'd0, 4'd0, 2'(sh));
            apply(4'd6,  2'd0, 4'(a), 4'd3, 4'd0, 4'd0, 2'(sh));
         end
      // R10: asynchronous clear with flags set
      apply(4'd2, 2'd0, 4'd0, 4'd1, 4'd0, 4'd0, 2'd0);
      @(negedge clk);
      rst_n = 1'b0;
      #0.5;
      check("R10", flags, 0, "flags after async reset");
      @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule